// File: doc/BRIEF.md
# Two-Operand Nibble-Immediate Processor Core

This block is a small multicycle processor core. It runs 16-bit instructions against a file of thirty-two 64-bit registers. Every operation reads register A and register B and, when it produces a value, writes that value back into register A. Instructions come from a word-addressed instruction port that is read combinationally. Bytes move over a separate byte-addressed data port. The core raises a request on that port and holds it until the memory answers with a valid strobe.

Constants are built a nibble at a time. An immediate instruction places a 4-bit value either in the low nibble or in the high nibble of a byte. Control flow uses a three-flag status register. Compare sets the flags. A conditional jump masks the flags with a field of the instruction and takes its target from a register, optionally relative to its own address. The core starts at a given start address after reset. Once the program counter moves beyond a parameterised limit, the core halts.

Top module: `nib_core`

## Requirements
- R1: An instruction is decoded as opcode = bits [15:10], A index = bits [9:5], B index/field = bits [4:0]. Instruction addresses count 16-bit words. Every instruction that does not jump moves the program counter to the current address plus one. Any opcode other than 1, 2 and 3 occupies exactly one fetch cycle.
- R2: Opcodes 5..13 write A with, in order: NOT A, A AND B, A OR B, A XOR B, A+B, A-B, A shifted left by B, A shifted right logically by B, A shifted right arithmetically by B. Shift counts use only B bits [5:0].
- R3: Opcode 4 replaces all 64 bits of A with B-field bits [4:1]. That value is shifted left by 4 when B-field bit 0 is 1.
- R4: Opcode 2 issues one read at the byte address held in B. It puts the returned byte into A bits [7:0] and leaves A bits [63:8] unchanged.
- R5: Opcode 3 issues one write of B bits [7:0] to the byte address held in A.
- R6: Opcode 1 issues a read at the address held in B, then a write of the returned byte to the address held in A. A request keeps its address, direction and data stable until the cycle in which valid is seen. The core does not fetch while a request is open.
- R7: Opcode 14 compares A and B unsigned. It sets status bit 0 for equal, bit 1 for A<B and bit 2 for A>B, clearing the other two bits. It never redirects the program counter.
- R8: Opcode 15 jumps when (B-field bits [3:1] AND status bits [2:0]) is nonzero. The target is the value of A, plus the current instruction address when B-field bit 0 is 1.
- R9: Opcode 0 and opcodes 16..63 change no register, no flag and no memory.
- R10: When the program counter exceeds PC_LIMIT, halted is 1, the program counter freezes and no data request is raised. This applies whether the limit is passed by a jump or by stepping.
- R11: Reset (synchronous, active low) loads the program counter from start_pc and clears every register and every status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pc | input | IA_W | Word address loaded into the program counter at reset |
| imem_addr | output | IA_W | Word address of the instruction being fetched |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_req | output | 1 | Data transaction open |
| dmem_we | output | 1 | 1 = byte write, 0 = byte read |
| dmem_addr | output | XLEN | Byte address of the transaction |
| dmem_wdata | output | 8 | Byte to write |
| dmem_valid | input | 1 | Transaction completes in this cycle |
| dmem_rdata | input | 8 | Read byte, valid with dmem_valid |
| halted | output | 1 | Program counter is beyond PC_LIMIT |

## Verification
Two things can fall in the same cycle. A data request can open and complete at once when memory answers with zero wait. A load's register write-back also lands on the same edge that advances the program counter, and the next instruction reads that register. The bench rotates the response delay through 0, 1, 2 and 3 cycles, so every memory opcode, including both halves of a copy, meets the zero-wait case and the stalled case. A behavioural instruction model predicts the fetch address for every free cycle and the transaction for every request cycle. Each clock is judged against that prediction, so a lost or repeated write-back shows up as a wrong stored byte or a wrong later fetch.

// File: rtl/nib_pkg.sv
// Shared definitions for the nibble-immediate core: instruction field
// widths, opcode values, sequencer states and the decoded instruction layout.
// Assumes the 16-bit encoding opcode[15:10], A[9:5], B[4:0].
package nib_pkg;
    localparam int INSN_W = 16;
    localparam int OPC_W  = 6;
    localparam int RID_W  = 5;
    localparam int FLAG_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 6'd0,
        OP_MCOPY = 6'd1,
        OP_LDB   = 6'd2,
        OP_STB   = 6'd3,
        OP_IMM   = 6'd4,
        OP_NOT   = 6'd5,
        OP_AND   = 6'd6,
        OP_OR    = 6'd7,
        OP_XOR   = 6'd8,
        OP_ADD   = 6'd9,
        OP_SUB   = 6'd10,
        OP_SHL   = 6'd11,
        OP_SHR   = 6'd12,
        OP_SAR   = 6'd13,
        OP_CMP   = 6'd14,
        OP_JMP   = 6'd15
    } opc_e;

    typedef enum logic {
        ST_RUN,
        ST_MEM
    } core_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [RID_W-1:0] ra;
        logic [RID_W-1:0] rb;
    } insn_t;
endpackage

// File: rtl/nib_regfile.sv
// General register file: NREG entries of XLEN bits, two combinational read
// ports and one synchronous write port. Synchronous active-low reset clears
// every entry. Assumes a single writer per cycle.
module nib_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_idx,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_val
);
    logic [XLEN-1:0] regs_q [NREG];

    // Clear on reset, otherwise write the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    // Combinational read ports.
    always_comb begin
        ra_val = regs_q[ra_idx];
        rb_val = regs_q[rb_idx];
    end
endmodule

// File: rtl/nib_alu.sv
// Result unit for the register-writing opcodes: nibble immediate, NOT,
// AND/OR/XOR, add, subtract and the three shifts. Purely combinational.
// Assumes XLEN is a power of two; shift counts use the low log2(XLEN) bits.
module nib_alu #(
    parameter int XLEN = 64
) (
    input  logic [nib_pkg::OPC_W-1:0] opc,
    input  logic [XLEN-1:0]           a_val,
    input  logic [XLEN-1:0]           b_val,
    input  logic [nib_pkg::RID_W-1:0] b_field,
    output logic [XLEN-1:0]           result
);
    import nib_pkg::*;
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] imm_val;

    assign shamt = b_val[SHW-1:0];

    // Nibble immediate, optionally moved into the high half of the byte.
    always_comb begin
        imm_val = XLEN'(b_field[4:1]);
        if (b_field[0]) begin
            imm_val = imm_val << 4;
        end
    end

    // Operation select.
    always_comb begin
        case (opc)
            OP_IMM:  result = imm_val;
            OP_NOT:  result = ~a_val;
            OP_AND:  result = a_val & b_val;
            OP_OR:   result = a_val | b_val;
            OP_XOR:  result = a_val ^ b_val;
            OP_ADD:  result = a_val + b_val;
            OP_SUB:  result = a_val - b_val;
            OP_SHL:  result = a_val << shamt;
            OP_SHR:  result = a_val >> shamt;
            OP_SAR:  result = XLEN'($signed(a_val) >>> shamt);
            default: result = a_val;
        endcase
    end
endmodule

// File: rtl/nib_core.sv
// Multicycle two-operand core. Fetches one instruction word per free cycle
// from a combinational instruction port, executes register operations in
// that cycle, and parks in a memory state for byte loads, stores and copies
// until the data port answers. Halts once the program counter is beyond
// PC_LIMIT. Assumes NREG = 32 to match the 5-bit register fields.
module nib_core #(
    parameter int               XLEN     = 64,
    parameter int               NREG     = 32,
    parameter int               IA_W     = 16,
    parameter logic [XLEN-1:0]  PC_LIMIT = XLEN'(32767)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IA_W-1:0] start_pc,
    output logic [IA_W-1:0] imem_addr,
    input  logic [15:0]     imem_rdata,
    output logic            dmem_req,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_addr,
    output logic [7:0]      dmem_wdata,
    input  logic            dmem_valid,
    input  logic [7:0]      dmem_rdata,
    output logic            halted
);
    import nib_pkg::*;
    localparam int RAW = $clog2(NREG);

    core_state_e       state_q;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   pc_next;
    logic [FLAG_W-1:0] flags_q;
    insn_t             ir_held_q;
    insn_t             ir;
    logic              second_q;
    logic [7:0]        byte_q;
    logic [XLEN-1:0]   va;
    logic [XLEN-1:0]   vb;
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   wr_val;
    logic              wr_en;
    logic              is_mem;
    logic              is_alu;
    logic              jmp_taken;
    logic              run_go;

    assign halted    = pc_q > PC_LIMIT;
    assign imem_addr = pc_q[IA_W-1:0];
    assign ir        = (state_q == ST_MEM) ? ir_held_q : insn_t'(imem_rdata);
    assign run_go    = (state_q == ST_RUN) && !halted;

    nib_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (RAW'(ir.ra)),
        .rb_idx (RAW'(ir.rb)),
        .ra_val (va),
        .rb_val (vb),
        .wr_en  (wr_en),
        .wr_idx (RAW'(ir.ra)),
        .wr_val (wr_val)
    );

    nib_alu #(.XLEN(XLEN)) u_alu (
        .opc     (ir.opc),
        .a_val   (va),
        .b_val   (vb),
        .b_field (ir.rb),
        .result  (alu_res)
    );

    // Opcode classes used by the sequencer.
    always_comb begin
        is_mem = (ir.opc == OP_MCOPY) || (ir.opc == OP_LDB) || (ir.opc == OP_STB);
        is_alu = (ir.opc >= OP_IMM) && (ir.opc <= OP_SAR);
    end

    // Jump condition and next program counter.
    always_comb begin
        jmp_taken = (ir.opc == OP_JMP) && ((ir.rb[3:1] & flags_q) != '0);
        pc_next   = pc_q + XLEN'(1);
        if (jmp_taken) begin
            pc_next = va + (ir.rb[0] ? pc_q : '0);
        end
    end

    // Register write-back: ALU result while running, load byte on completion.
    always_comb begin
        wr_en  = run_go && is_alu;
        wr_val = alu_res;
        if (state_q == ST_MEM && dmem_valid && ir.opc == OP_LDB) begin
            wr_en  = 1'b1;
            wr_val = {va[XLEN-1:8], dmem_rdata};
        end
    end

    // Data port drive; operands come straight from the unchanged registers.
    always_comb begin
        dmem_req   = (state_q == ST_MEM);
        dmem_we    = dmem_req && ((ir.opc == OP_STB) || (ir.opc == OP_MCOPY && second_q));
        dmem_addr  = ((ir.opc == OP_LDB) || (ir.opc == OP_MCOPY && !second_q)) ? vb : va;
        dmem_wdata = (ir.opc == OP_STB) ? vb[7:0] : byte_q;
    end

    // Sequencer: program counter, flags, held instruction and copy phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            pc_q      <= XLEN'(start_pc);
            flags_q   <= '0;
            ir_held_q <= '0;
            second_q  <= 1'b0;
            byte_q    <= '0;
        end else if (state_q == ST_RUN) begin
            if (!halted) begin
                ir_held_q <= ir;
                second_q  <= 1'b0;
                if (is_mem) begin
                    state_q <= ST_MEM;
                end else begin
                    pc_q <= pc_next;
                end
                if (ir.opc == OP_CMP) begin
                    flags_q <= {va > vb, va < vb, va == vb};
                end
            end
        end else if (dmem_valid) begin
            if (ir.opc == OP_MCOPY && !second_q) begin
                second_q <= 1'b1;
                byte_q   <= dmem_rdata;
            end else begin
                state_q <= ST_RUN;
                pc_q    <= pc_q + XLEN'(1);
            end
        end
    end
endmodule

// File: rtl/nib_core_chk.sv
// Port-level protocol checker for nib_core, attached by bind below.
// Assumes the bench holds rst_n low from time zero.
module nib_core_chk #(
    parameter int XLEN = 64,
    parameter int IA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IA_W-1:0] imem_addr,
    input logic [15:0]     imem_rdata,
    input logic            dmem_req,
    input logic            dmem_we,
    input logic [XLEN-1:0] dmem_addr,
    input logic            dmem_valid,
    input logic            halted
);
    logic free_fetch;
    assign free_fetch = !halted && !dmem_req;

    // R6: an open request keeps its address and direction until valid.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && !dmem_valid) |=> (dmem_req && $stable(dmem_addr) && $stable(dmem_we)));

    // R1: register-writing opcodes step to the next word.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fetch && imem_rdata[15:10] >= 6'd4 && imem_rdata[15:10] <= 6'd13)
        |=> (imem_addr == $past(imem_addr) + IA_W'(1)));

    // R7: compare never redirects.
    assert_cmp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fetch && imem_rdata[15:10] == 6'd14) |=> (imem_addr == $past(imem_addr) + IA_W'(1)));

    // R4: a byte load opens a read next cycle.
    assert_load_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fetch && imem_rdata[15:10] == 6'd2) |=> (dmem_req && !dmem_we));

    // R5: a byte store opens a write next cycle.
    assert_store_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fetch && imem_rdata[15:10] == 6'd3) |=> (dmem_req && dmem_we));

    // R10: halt is permanent and freezes the fetch address.
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    // R10: no data traffic while halted.
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_req);
endmodule

bind nib_core nib_core_chk #(.XLEN(XLEN), .IA_W(IA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_req   (dmem_req),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_valid (dmem_valid),
    .halted     (halted)
);

// File: tb/tb_nib_core.sv
// Bench: behavioural instruction model builds the expected fetch and data
// transaction streams; every clock the core's ports are judged against them.
module tb_nib_core;
    localparam logic [63:0] LIMIT = 64'd120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] start_pc = 16'd0;
    logic [15:0] imem_addr;
    logic [15:0] imem_rdata;
    logic        dmem_req;
    logic        dmem_we;
    logic [63:0] dmem_addr;
    logic [7:0]  dmem_wdata;
    logic        dmem_valid = 1'b0;
    logic [7:0]  dmem_rdata = 8'h00;
    logic        halted;

    always #5 clk = ~clk;

    nib_core #(.PC_LIMIT(LIMIT)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pc   (start_pc),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_req   (dmem_req),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_valid (dmem_valid),
        .dmem_rdata (dmem_rdata),
        .halted     (halted)
    );

    typedef struct {
        logic [63:0] addr;
        bit          we;
        logic [7:0]  data;
        string       tag;
    } txn_t;

    logic [15:0] imem [256];
    string       itag [256];
    logic [7:0]  dm [256];
    logic [7:0]  mm [256];
    txn_t        exp_txn [$];
    logic [63:0] exp_pc [$];
    string       exp_tag [$];
    logic [63:0] final_pc;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          wp;
    bit          active = 1'b0;
    int          wcnt = 0;
    int          lat = 0;
    int          ntx = 0;
    int          lat_mode = 0;

    assign imem_rdata = (imem_addr < 16'd256) ? imem[imem_addr[7:0]] : 16'h0000;

    function automatic void chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic void emit(int op, int a, int b, string tag = "R1");
        imem[wp] = {op[5:0], a[4:0], b[4:0]};
        itag[wp] = tag;
        wp++;
    endfunction

    function automatic void push_txn(logic [63:0] addr, bit we, logic [7:0] data, string tag);
        txn_t t;
        t.addr = addr;
        t.we   = we;
        t.data = data;
        t.tag  = tag;
        exp_txn.push_back(t);
    endfunction

    // Behavioural instruction-level model of the requirements.
    task automatic build_model(input logic [63:0] start);
        logic [63:0] r [32];
        logic [2:0]  st;
        logic [63:0] pc;
        logic [63:0] va;
        logic [63:0] vb;
        logic [15:0] w;
        string       ftag;
        string       t;
        bit          jumped;
        int          op;
        int          guard;
        for (int i = 0; i < 32; i++) r[i] = 64'd0;
        st = 3'd0;
        pc = start;
        ftag = "R11";
        guard = 0;
        exp_pc.delete();
        exp_tag.delete();
        exp_txn.delete();
        while (pc <= LIMIT && guard < 2000) begin
            guard++;
            exp_pc.push_back(pc);
            exp_tag.push_back(ftag);
            ftag = "R1";
            w = imem[pc[7:0]];
            t = itag[pc[7:0]];
            op = int'(w[15:10]);
            va = r[w[9:5]];
            vb = r[w[4:0]];
            jumped = 1'b0;
            case (op)
                1: begin
                    push_txn(vb, 1'b0, 8'h00, t);
                    push_txn(va, 1'b1, mm[vb[7:0]], t);
                    mm[va[7:0]] = mm[vb[7:0]];
                end
                2: begin
                    push_txn(vb, 1'b0, 8'h00, t);
                    r[w[9:5]] = {va[63:8], mm[vb[7:0]]};
                end
                3: begin
                    push_txn(va, 1'b1, vb[7:0], t);
                    mm[va[7:0]] = vb[7:0];
                end
                4:  r[w[9:5]] = w[0] ? {56'd0, w[4:1], 4'd0} : {60'd0, w[4:1]};
                5:  r[w[9:5]] = ~va;
                6:  r[w[9:5]] = va & vb;
                7:  r[w[9:5]] = va | vb;
                8:  r[w[9:5]] = va ^ vb;
                9:  r[w[9:5]] = va + vb;
                10: r[w[9:5]] = va - vb;
                11: r[w[9:5]] = va << vb[5:0];
                12: r[w[9:5]] = va >> vb[5:0];
                13: r[w[9:5]] = $signed(va) >>> vb[5:0];
                14: st = {va > vb, va < vb, va == vb};
                15: begin
                    if ((w[3:1] & st) != 3'd0) begin
                        pc = va + (w[0] ? pc : 64'd0);
                        jumped = 1'b1;
                        ftag = "R8";
                    end
                end
                default: ;
            endcase
            if (!jumped) pc = pc + 64'd1;
        end
        final_pc = pc;
    endtask

    // Per-clock comparison and data memory responder, away from the active edge.
    always @(negedge clk) begin
        txn_t t;
        if (active) begin
            if (dmem_valid) begin
                dmem_valid = 1'b0;
                wcnt = 0;
            end
            if (halted) begin
                chk(dmem_req == 1'b0, "R10", "request while halted", 64'(dmem_req), 64'd0);
                chk(imem_addr == final_pc[15:0], "R10", "frozen pc", 64'(imem_addr), 64'(final_pc[15:0]));
            end else if (dmem_req) begin
                if (exp_txn.size() == 0) begin
                    chk(1'b0, "R6", "unexpected data request", dmem_addr, 64'd0);
                end else begin
                    t = exp_txn[0];
                    chk(dmem_addr == t.addr, t.tag, "data address", dmem_addr, t.addr);
                    chk(dmem_we == t.we, t.tag, "data direction", 64'(dmem_we), 64'(t.we));
                    if (t.we) chk(dmem_wdata == t.data, t.tag, "write byte", 64'(dmem_wdata), 64'(t.data));
                    if (wcnt >= lat) begin
                        if (dmem_we) dm[dmem_addr[7:0]] = dmem_wdata;
                        else dmem_rdata = dm[dmem_addr[7:0]];
                        dmem_valid = 1'b1;
                        void'(exp_txn.pop_front());
                        ntx++;
                        lat = (lat_mode != 0) ? (ntx % 4) : 0;
                    end else begin
                        wcnt++;
                    end
                end
            end else begin
                if (exp_pc.size() == 0) begin
                    chk(1'b0, "R10", "fetch past model halt", 64'(imem_addr), final_pc);
                end else begin
                    chk(imem_addr == exp_pc[0][15:0], exp_tag[0], "fetch address",
                        64'(imem_addr), 64'(exp_pc[0][15:0]));
                    void'(exp_pc.pop_front());
                    exp_tag.pop_front();
                end
            end
        end
    end

    task automatic run_prog(input logic [15:0] sp, input int mode);
        int waitc;
        active = 1'b0;
        rst_n = 1'b0;
        start_pc = sp;
        lat_mode = mode;
        ntx = 0;
        lat = 0;
        wcnt = 0;
        dmem_valid = 1'b0;
        for (int i = 0; i < 256; i++) begin
            dm[i] = 8'(i * 7 + 3);
            mm[i] = dm[i];
        end
        build_model(64'(sp));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == sp, "R11", "pc during reset", 64'(imem_addr), 64'(sp));
        chk(halted == 1'b0 && dmem_req == 1'b0, "R11", "idle during reset",
            64'({halted, dmem_req}), 64'd0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        active = 1'b1;
        waitc = 0;
        while (!halted && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        chk(halted == 1'b1, "R10", "halt reached", 64'(halted), 64'd1);
        repeat (6) @(negedge clk);
        chk(exp_pc.size() == 0, "R10", "unexecuted fetches left", 64'(exp_pc.size()), 64'd0);
        chk(exp_txn.size() == 0, "R6", "unissued transactions left", 64'(exp_txn.size()), 64'd0);
        active = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual still running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Program one: starts at word 4, ends by jumping beyond the limit.
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'h0000;
            itag[i] = "R9";
        end
        wp = 4;
        emit(4, 1, 6);            // r1 = 0x03
        emit(4, 2, 21);           // r2 = 0xA0 (high nibble)
        emit(9, 1, 2);            // r1 = 0xA3
        emit(4, 5, 3);            // r5 = 0x10
        emit(3, 5, 1, "R5");      // [0x10] = A3
        emit(5, 6, 0);            // r6 = all ones
        emit(2, 6, 5, "R4");      // r6 low byte from [0x10]
        emit(4, 4, 16);           // r4 = 8
        emit(12, 6, 4);           // r6 >>= 8, upper ones must survive the load
        emit(4, 7, 5);            // r7 = 0x20
        emit(3, 7, 6, "R4");      // [0x20] = FF
        emit(4, 7, 7);            // r7 = 0x30
        emit(1, 7, 5, "R6");      // [0x30] = [0x10]
        emit(4, 8, 11);           // r8 = 0x50
        emit(4, 9, 24);           // r9 = 0x0C
        emit(7, 8, 9);            // OR
        emit(4, 5, 9);            // r5 = 0x40
        emit(3, 5, 8, "R2");
        emit(4, 10, 12);          // r10 = 6
        emit(6, 8, 10);           // AND
        emit(8, 8, 2);            // XOR
        emit(10, 8, 9);           // SUB
        emit(3, 5, 8, "R2");
        emit(4, 11, 31);          // r11 = 0xF0, low six bits 48
        emit(5, 12, 0);
        emit(12, 12, 11);         // logical right by 48
        emit(12, 12, 4);
        emit(3, 5, 12, "R2");
        emit(4, 13, 17);          // r13 = 0x80
        emit(4, 14, 7);
        emit(4, 15, 16);
        emit(9, 14, 15);          // r14 = 0x38
        emit(11, 13, 14);         // left by 56
        emit(13, 13, 14);         // arithmetic right by 56
        emit(12, 13, 14);         // logical right by 56
        emit(3, 5, 13, "R2");
        emit(0, 1, 1, "R9");
        emit(20, 1, 2, "R9");
        emit(63, 1, 1, "R9");
        emit(3, 5, 1, "R9");
        emit(4, 6, 14);           // r6 = 7, whole register replaced
        emit(12, 6, 4);
        emit(3, 5, 6, "R3");
        emit(3, 5, 2, "R3");
        emit(14, 1, 2, "R7");     // greater
        emit(15, 0, 6, "R8");     // mask eq|lt: not taken
        emit(4, 3, 6);            // r3 = 3
        emit(15, 3, 9, "R8");     // relative, mask gt: skip two words
        emit(3, 5, 0, "R8");
        emit(3, 5, 0, "R8");
        emit(14, 2, 1, "R7");     // less
        emit(4, 3, 13);           // r3 = 0x60
        emit(15, 3, 4, "R8");     // absolute to 96
        emit(3, 5, 0, "R8");
        wp = 96;
        emit(14, 1, 1, "R7");     // equal
        emit(3, 5, 1, "R7");
        emit(4, 3, 31);           // r3 = 240
        emit(15, 3, 2, "R10");    // jump beyond the limit
        run_prog(16'd4, 1);

        // Program two: reset state, then stepping past the limit.
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'h0000;
            itag[i] = "R9";
        end
        wp = 110;
        emit(15, 0, 14, "R11");   // flags cleared: not taken
        emit(3, 0, 1, "R11");     // r1 cleared: [0] = 0
        run_prog(16'd110, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule